// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Core

This block is a small programmable logic core that is configured at run time. A programmable AND plane forms product terms from the dedicated inputs, from the output feedback, or from the complements of either. A fixed OR plane combines the terms that belong to each output. Each output cell is set on its own as combinational or clocked, as active high or active low, and, when clocked, as a plain sum or as an exclusive-OR of two term groups. In combinational mode the first product term of an output drives that output's enable and does not take part in the sum.

The configuration bank is a plain register chain. It is filled one bit per clock through a serial input while the load strobe is high. The output enables stay low while loading and for one cycle after loading ends, so a partly written map never reaches the pins. Combinational outputs may feed later combinational outputs. Acyclic chains up to one per output settle within the same cycle.

Top module: `sop_logic_core`

## Requirements
- R1: A product term is the AND of the literals whose fuse bit is 1. A term with every fuse set to 1 evaluates to 0, and a term with every fuse set to 0 evaluates to 1.
- R2: While `cfg_load` is high, each rising edge shifts `cfg_in` into bank bit 0 and moves every other bit up one place. After CFG_W edges, the first bit shifted in sits at bit CFG_W-1. The fuse for output o, term t, signal s and polarity c (0 true, 1 complement) is bank bit ((o*N_PT+t)*2*(N_IN+N_OUT) + 2*s + c). Signals 0..N_IN-1 are `din` and signal N_IN+o is the feedback of output o. The mode bits of output o start at bit N_OUT*N_PT*2*(N_IN+N_OUT) + 3*o, in the order +0 clocked, +1 active low, +2 exclusive-OR. The bank changes only while loading.
- R3: In combinational mode, `dout[o]` is the OR of terms 1..N_PT-1, inverted when the active-low bit is set. `doe[o]` equals term 0.
- R4: In clocked mode, the output register takes the OR of all N_PT terms on each rising edge. `dout[o]` is the register value, inverted when the active-low bit is set, and `doe[o]` is 1.
- R5: In clocked mode with the exclusive-OR bit set, the register takes (OR of terms 0..N_PT/2-1) XOR (OR of the remaining terms). The exclusive-OR bit has no effect in combinational mode.
- R6: A clocked output feeds back its register value before polarity. A combinational output feeds back its `dout` value after polarity, whatever its enable. Combinational chains with no loop settle in the same cycle.
- R7: `doe` is all zero while `cfg_load` is high and in the cycle after it falls.
- R8: A synchronous `rst` clears every output register to 0, so a clocked active-low output then shows 1. Reset leaves the configuration bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; output registers and the bank update on its rising edge |
| rst | input | 1 | Synchronous reset of the output registers, active high |
| cfg_load | input | 1 | Serial configuration load strobe |
| cfg_in | input | 1 | Serial configuration data, one bit per clock |
| din | input | N_IN | Dedicated logic inputs |
| dout | output | N_OUT | Output values after polarity |
| doe | output | N_OUT | Per-output enable |

## Verification
On every cycle, the assertions check these points:
- the shift-in of the bank and that it holds when not loading;
- the quiet enables during and just after a load;
- the forced enable of clocked outputs;
- the clearing of the registers under reset.

Only the bench's sweeps can show the rest. This covers the function itself:
- the product-term semantics, including the all-fuses and no-fuses cases;
- combinational enables and polarity;
- exclusive-OR grouping, and that the exclusive-OR bit is ignored in combinational mode;
- the pre-polarity register feedback and the settling of a two-deep combinational chain;
- that two different loaded maps take effect in the documented bit order.

// File: rtl/sop_logic_core.sv
module sop_logic_core #(
  parameter int N_IN  = 10,
  parameter int N_OUT = 8,
  parameter int N_PT  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_in,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout,
  output logic [N_OUT-1:0] doe
);
  localparam int NSIG    = N_IN + N_OUT;
  localparam int NLIT    = 2 * NSIG;
  localparam int PT_BITS = N_OUT * N_PT * NLIT;
  localparam int CFG_W   = PT_BITS + 3 * N_OUT;
  localparam int SPLIT   = N_PT / 2;

  logic [CFG_W-1:0] bank;
  logic [N_OUT-1:0] q, reg_mode, inv_mode, xor_mode;
  logic [N_OUT-1:0] comb_val, reg_next, oe_term;
  logic             load_d, gate;

  always_ff @(posedge clk)
    if (cfg_load) bank <= {bank[CFG_W-2:0], cfg_in};

  for (genvar o = 0; o < N_OUT; o++) begin : g_mode
    assign reg_mode[o] = bank[PT_BITS + 3*o];
    assign inv_mode[o] = bank[PT_BITS + 3*o + 1];
    assign xor_mode[o] = bank[PT_BITS + 3*o + 2];
  end

  function automatic logic pt_eval(input logic [NLIT-1:0] f, input logic [NSIG-1:0] s);
    logic [NLIT-1:0] lit;
    for (int k = 0; k < NSIG; k++) begin
      lit[2*k]   = s[k];
      lit[2*k+1] = ~s[k];
    end
    return &(lit | ~f);
  endfunction

  // One pass per output lets any loop-free combinational chain settle.
  always_comb begin : settle
    logic [N_OUT-1:0] fb;
    logic [N_PT-1:0]  term;
    fb       = q;
    term     = '0;
    comb_val = '0;
    reg_next = '0;
    oe_term  = '0;
    for (int p = 0; p < N_OUT; p++) begin
      for (int o = 0; o < N_OUT; o++) begin
        for (int t = 0; t < N_PT; t++)
          term[t] = pt_eval(bank[(o*N_PT + t)*NLIT +: NLIT], {fb, din});
        comb_val[o] = (|term[N_PT-1:1]) ^ inv_mode[o];
        oe_term[o]  = term[0];
        reg_next[o] = xor_mode[o] ? ((|term[SPLIT-1:0]) ^ (|term[N_PT-1:SPLIT])) : (|term);
      end
      fb = (reg_mode & q) | (~reg_mode & comb_val);
    end
  end

  always_ff @(posedge clk) begin
    load_d <= rst ? 1'b0 : cfg_load;
    q      <= rst ? '0 : reg_next;
  end

  assign gate = ~cfg_load & ~load_d;
  assign dout = (reg_mode & (q ^ inv_mode)) | (~reg_mode & comb_val);
  assign doe  = {N_OUT{gate}} & (reg_mode | oe_term);

  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> bank[0] == $past(cfg_in));
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(bank));
  p_oe_quiet_now_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> doe == '0);
  p_oe_quiet_after_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> doe == '0);
  p_reg_oe_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_load && !$past(cfg_load)) |-> (doe & reg_mode) == reg_mode);
  p_reg_clear_r8: assert property (@(posedge clk)
    rst |=> q == '0);
endmodule

// File: tb/sop_logic_core_tb_top.sv
module sop_logic_core_tb_top;
  localparam int NI = 10, NO = 8, NP = 8;
  localparam int NL = 2 * (NI + NO);
  localparam int MB = NO * NP * NL;
  localparam int W  = MB + 3 * NO;

  logic clk = 1'b0, rst = 1'b1, cfg_load = 1'b0, cfg_in = 1'b0;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] dout, doe;
  logic [W-1:0]  cfg;
  int runs = 0, fails = 0;
  logic [2:0] qm;

  always #4 clk = ~clk;

  sop_logic_core #(.N_IN(NI), .N_OUT(NO), .N_PT(NP)) dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_in(cfg_in),
    .din(din), .dout(dout), .doe(doe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int fi(int o, int t, int s, int c);
    return (o*NP + t)*NL + 2*s + c;
  endfunction

  task automatic open_pt(int o, int t);
    for (int k = 0; k < NL; k++) cfg[fi(o, t, 0, 0) + k] = 1'b0;
  endtask

  task automatic add_lit(int o, int t, int s, int c);
    cfg[fi(o, t, s, c)] = 1'b1;
  endtask

  task automatic set_mode(int o, bit clocked, bit low, bit x);
    cfg[MB + 3*o]     = clocked;
    cfg[MB + 3*o + 1] = low;
    cfg[MB + 3*o + 2] = x;
  endtask

  task automatic load_cfg();
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_in   = cfg[i];
      if (i == W/2) chk(doe == '0, "R7 during load", 32'(doe), 0);
    end
    @(negedge clk);
    cfg_load = 1'b0;
    #1 chk(doe == '0, "R7 cycle after load", 32'(doe), 0);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    qm = 3'b000;
  endtask

  task automatic sweep_a(int n);
    logic [NI-1:0] d;
    logic e0, e3;
    logic [NO-1:0] eo, ee;
    for (int v = 0; v < n; v++) begin
      d  = NI'(v);
      din = d;
      #1;
      e0 = (d[0] & d[1]) | (~d[2] & d[3]);
      e3 = e0 & d[5];
      eo = {3'b000, ~e3, e3, 1'b1, ~d[4], e0};
      ee = {5'b11111, 1'b0, d[9], 1'b1};
      chk(dout[4:0] == eo[4:0], "R1 R3 R5 R6 comb outputs", 32'(dout[4:0]), 32'(eo[4:0]));
      chk(doe == ee, "R1 R3 R4 enables", 32'(doe), 32'(ee));
      @(negedge clk);
      qm = {qm[2] ^ d[2], d[0] ^ d[1], (d[6] & d[7]) | d[8]};
      chk(dout[7:5] == {~qm[2], ~qm[1], qm[0]}, "R4 R5 R6 clocked outputs",
          32'(dout[7:5]), 32'({~qm[2], ~qm[1], qm[0]}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d", runs, 0);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    cfg = '1;
    for (int o = 0; o < NO; o++) set_mode(o, 0, 0, 0);
    set_mode(0, 0, 0, 1);
    open_pt(0, 0);
    open_pt(0, 1); add_lit(0, 1, 0, 0); add_lit(0, 1, 1, 0);
    open_pt(0, 2); add_lit(0, 2, 2, 1); add_lit(0, 2, 3, 0);
    set_mode(1, 0, 1, 0);
    open_pt(1, 0); add_lit(1, 0, 9, 0);
    open_pt(1, 1); add_lit(1, 1, 4, 0);
    open_pt(2, 2);
    open_pt(3, 0);
    open_pt(3, 1); add_lit(3, 1, NI + 0, 0); add_lit(3, 1, 5, 0);
    open_pt(4, 0);
    open_pt(4, 1); add_lit(4, 1, NI + 3, 1);
    set_mode(5, 1, 0, 0);
    open_pt(5, 0); add_lit(5, 0, 6, 0); add_lit(5, 0, 7, 0);
    open_pt(5, 1); add_lit(5, 1, 8, 0);
    set_mode(6, 1, 1, 1);
    open_pt(6, 0); add_lit(6, 0, 0, 0);
    open_pt(6, 4); add_lit(6, 4, 1, 0);
    set_mode(7, 1, 1, 0);
    open_pt(7, 0); add_lit(7, 0, NI + 7, 1); add_lit(7, 0, 2, 0);
    open_pt(7, 1); add_lit(7, 1, NI + 7, 0); add_lit(7, 1, 2, 1);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    load_cfg();
    chk(doe[0] == 1'b1, "R7 enables return after load", 32'(doe[0]), 1);
    din = 10'h1FF;
    do_reset();
    chk(dout[7:5] == 3'b110, "R8 reset state of clocked outputs", 32'(dout[7:5]), 32'(3'b110));
    sweep_a(1 << NI);
    do_reset();
    chk(dout[7:5] == 3'b110, "R8 second reset", 32'(dout[7:5]), 32'(3'b110));
    sweep_a(64);

    cfg = '1;
    for (int o = 0; o < NO; o++) begin
      set_mode(o, 0, o % 2, 0);
      open_pt(o, 0); add_lit(o, 0, 9, 1);
      open_pt(o, 1); add_lit(o, 1, o, 0);
    end
    load_cfg();
    do_reset();
    for (int v = 0; v < (1 << NI); v++) begin
      din = NI'(v);
      #1;
      chk(dout == (din[7:0] ^ 8'hAA), "R2 R3 second map values", 32'(dout), 32'(din[7:0] ^ 8'hAA));
      chk(doe == {NO{~din[9]}}, "R2 R3 second map enables", 32'(doe), 32'({NO{~din[9]}}));
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule